// File: doc/BRIEF.md
# Comma-Aligning Deserializer

This block takes a retimed serial stream, one bit on every bit-clock cycle, and turns it into 10-bit parallel characters. Two complementary character clocks run at one twentieth of the bit rate. Each half period carries one character, so every rising edge of either clock brings a new character onto the bus. Both clocks are produced as registered levels in the bit-clock domain and change only when a new character is loaded.

While alignment is enabled, the block searches the incoming bits for a 7-bit comma pattern. When a comma arrives out of place, the block moves the character boundaries and the even/odd character phase. After the move, later commas sit in the low seven bits of a character that appears on the rising edge of the complementary clock. A realignment only lengthens the current character period and never shortens it. The comma that triggers the realignment may be dropped. While alignment is disabled, the current framing is kept no matter what the data contains. A flag output marks every character on the bus that holds a comma in its low bits.

Top module: `comma_align_deser`

## Requirements
- R1: Each character on `par_char` holds the 10 most recently received bits at the moment it is loaded, with the earliest of them in bit 0 and the latest in bit 9.
- R2: `char_clk` and `char_clkn` are always complementary and toggle exactly when a new character is loaded. During and right after reset, `char_clkn` is 0, `char_clk` is 1, `par_char` is 0 and `comma_hit` is 0.
- R3: When no realignment takes place, a new character is loaded every 10 bit cycles.
- R4: While `align_en` is 0, the framing never changes: characters keep coming every 10 bit cycles, even when commas arrive at other offsets.
- R5: While `align_en` is 1, the comma pattern is bits R0..R6 = 0,0,1,1,1,1,1, with R0 received first. After the first comma, every later comma appears in a character whose load drives `char_clkn` to 1.
- R6: No character period is ever shorter than 10 bit cycles. Realignment only lengthens periods.
- R7: A comma that is already framed and falls on the `char_clkn` rising load causes no adjustment, and the character period stays at 10.
- R8: A comma that is correctly framed but falls on the `char_clk` rising load keeps the framing. It inserts exactly one extra character time, so the longest period seen is 20 bit cycles, and that comma is dropped.
- R9: `comma_hit` is 1 exactly while `par_char` bits 6..0 equal 1111100 (bit 0 = R0). This holds whatever the value of `align_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_bit | input | 1 | Retimed serial data bit |
| align_en | input | 1 | 1 enables comma search and realignment |
| par_char | output | 10 | Parallel character; bit 0 was received first |
| char_clk | output | 1 | True character clock, 1/20 of the bit rate |
| char_clkn | output | 1 | Complementary character clock |
| comma_hit | output | 1 | High while `par_char` holds a comma in bits 6..0 |

## Verification
The assertions assume that `ser_bit` and `align_en` are synchronous to the bit clock. They also assume that commas never follow one another closer than a character apart, as in any 8B/10B-style stream. The stimulus alternates a negative-disparity comma character with a data character whose joints can never form the pattern by accident. Every input change is made on the falling edge. Framing offsets are introduced only by inserting whole bits or whole characters into that stream, so each resulting shift and stretch has one known expected outcome.

// File: rtl/cad_pkg.sv
package cad_pkg;
  localparam int unsigned CHAR_BITS  = 10;
  localparam int unsigned COMMA_BITS = 7;
  // bit i corresponds to character position Ri
  localparam logic [COMMA_BITS-1:0] COMMA_CODE = 7'b1111100;

  // Bit cycles from the comma sighting to the next load.
  // next_ph is the phase that will hold when that load happens.
  // room says the short lag still yields a full-length period.
  function automatic int unsigned realign_gap(input int unsigned char_w,
                                              input int unsigned comma_w,
                                              input logic next_ph,
                                              input logic room);
    int unsigned lag;
    lag = char_w - comma_w;
    if (next_ph) return lag + char_w;
    if (room) return lag;
    return lag + 2 * char_w;
  endfunction
endpackage

// File: rtl/cad_window.sv
module cad_window
  import cad_pkg::*;
#(
  parameter int unsigned CHAR_W = CHAR_BITS,
  parameter int unsigned COMMA_W = COMMA_BITS,
  parameter logic [COMMA_W-1:0] COMMA_PAT = COMMA_CODE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_bit,
  output logic [CHAR_W-1:0] win,
  output logic              comma_seen
);
  logic [CHAR_W-2:0] hist_q;

  // newest bit lands at the top, oldest sits at bit 0
  assign win = {ser_bit, hist_q};
  // the most recent COMMA_W bits form a comma whose R0 is at CHAR_W-COMMA_W
  assign comma_seen = (win[CHAR_W-1 -: COMMA_W] == COMMA_PAT);

  always_ff @(posedge clk) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= win[CHAR_W-1:1];
  end
endmodule

// File: rtl/cad_framer.sv
module cad_framer
  import cad_pkg::*;
#(
  parameter int unsigned CHAR_W = CHAR_BITS,
  parameter int unsigned COMMA_W = COMMA_BITS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic align_en,
  input  logic comma_seen,
  output logic load
);
  localparam int unsigned LAG      = CHAR_W - COMMA_W;
  localparam int unsigned MAX_GAP  = LAG + 2 * CHAR_W;
  localparam int unsigned REM_W    = $clog2(MAX_GAP + 1);
  localparam int unsigned AGE_MAX  = MAX_GAP + CHAR_W;
  localparam int unsigned AGE_W    = $clog2(AGE_MAX + 1);
  localparam int unsigned ROOM_AGE = CHAR_W - LAG - 1;

  logic [REM_W-1:0] rem_q;
  logic [AGE_W-1:0] age_q;
  logic             phase_q;
  logic             phase_next;
  logic             room;
  logic             realign_req;
  logic [REM_W-1:0] gap_m1;

  assign load        = (rem_q == '0);
  assign phase_next  = load ? ~phase_q : phase_q;
  assign room        = !load && (age_q >= AGE_W'(ROOM_AGE));
  assign realign_req = align_en && comma_seen;

  always_comb begin
    gap_m1 = REM_W'(realign_gap(CHAR_W, COMMA_W, phase_next, room) - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q   <= REM_W'(CHAR_W - 1);
      age_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      phase_q <= phase_next;
      if (load)                         age_q <= '0;
      else if (age_q != AGE_W'(AGE_MAX)) age_q <= age_q + 1'b1;
      if (realign_req)  rem_q <= gap_m1;
      else if (load)    rem_q <= REM_W'(CHAR_W - 1);
      else              rem_q <= rem_q - 1'b1;
    end
  end

  // R6: a load never comes before a full character time
  assert_min_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> age_q >= AGE_W'(CHAR_W - 1));

  // R4: with search disabled the countdown runs undisturbed
  assert_hold_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!align_en && !load) |=> rem_q == $past(rem_q) - 1'b1);

  assert_hold_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!align_en && load) |=> rem_q == REM_W'(CHAR_W - 1));

  // R7: an already placed comma on the right phase leaves the grid alone
  assert_keep_grid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (realign_req && rem_q == REM_W'(LAG) && !phase_q) |=> rem_q == REM_W'(LAG - 1));
endmodule

// File: rtl/cad_outreg.sv
module cad_outreg
  import cad_pkg::*;
#(
  parameter int unsigned CHAR_W = CHAR_BITS,
  parameter int unsigned COMMA_W = COMMA_BITS,
  parameter logic [COMMA_W-1:0] COMMA_PAT = COMMA_CODE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CHAR_W-1:0] win,
  output logic [CHAR_W-1:0] par_char,
  output logic              comma_hit,
  output logic              char_clk,
  output logic              char_clkn
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_char  <= '0;
      comma_hit <= 1'b0;
      char_clk  <= 1'b1;
      char_clkn <= 1'b0;
    end else if (load) begin
      par_char  <= win;
      comma_hit <= (win[COMMA_W-1:0] == COMMA_PAT);
      char_clk  <= ~char_clk;
      char_clkn <= ~char_clkn;
    end
  end

  // R2: the two character clocks never agree
  assert_complement_R2: assert property (@(posedge clk) disable iff (!rst_n)
    char_clk != char_clkn);
endmodule

// File: rtl/comma_align_deser.sv
module comma_align_deser
  import cad_pkg::*;
#(
  parameter int unsigned CHAR_W = CHAR_BITS,
  parameter int unsigned COMMA_W = COMMA_BITS,
  parameter logic [COMMA_W-1:0] COMMA_PAT = COMMA_CODE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_bit,
  input  logic              align_en,
  output logic [CHAR_W-1:0] par_char,
  output logic              char_clk,
  output logic              char_clkn,
  output logic              comma_hit
);
  logic [CHAR_W-1:0] win;
  logic              comma_seen;
  logic              load;

  cad_window #(.CHAR_W(CHAR_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT)) u_window (
    .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .win(win), .comma_seen(comma_seen)
  );

  cad_framer #(.CHAR_W(CHAR_W), .COMMA_W(COMMA_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .align_en(align_en), .comma_seen(comma_seen), .load(load)
  );

  cad_outreg #(.CHAR_W(CHAR_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT)) u_outreg (
    .clk(clk), .rst_n(rst_n), .load(load), .win(win),
    .par_char(par_char), .comma_hit(comma_hit),
    .char_clk(char_clk), .char_clkn(char_clkn)
  );
endmodule

// File: tb/tb_comma_align_deser.sv
`timescale 1ns/1ps
module tb_comma_align_deser;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_bit = 1'b0;
  logic       align_en = 1'b0;
  logic [9:0] par_char;
  logic       char_clk, char_clkn, comma_hit;

  // R0..R9 = 0011111010 and 1010101010, bit 0 sent first
  localparam logic [9:0] K_CHAR = 10'b0101111100;
  localparam logic [9:0] D_CHAR = 10'b0101010101;

  int total = 0;
  int bad = 0;
  logic [9:0] hist = '0;
  logic prev_clkn = 1'b0;
  int since = 0;
  int w_min, w_max, w_loads, w_commas, w_wrong;

  always #2.5 clk = ~clk;

  comma_align_deser dut (
    .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .align_en(align_en),
    .par_char(par_char), .char_clk(char_clk), .char_clkn(char_clkn), .comma_hit(comma_hit)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic window_start();
    w_min = 1000; w_max = 0; w_loads = 0; w_commas = 0; w_wrong = 0;
  endtask

  // called on a falling edge; returns on the next falling edge
  task automatic send_bit(input logic b);
    ser_bit = b;
    hist = {b, hist[9:1]};
    @(negedge clk);
    since++;
    if (char_clkn !== prev_clkn) begin
      check(char_clk === ~char_clkn, "R2", "clocks complementary", char_clk, !char_clkn);
      check(par_char === hist, "R1", "character bit order", par_char, hist);
      check(since >= 10, "R6", "period length", since, 10);
      check(comma_hit === (par_char[6:0] == 7'b1111100), "R9", "comma flag",
            comma_hit, par_char[6:0] == 7'b1111100);
      if (since < w_min) w_min = since;
      if (since > w_max) w_max = since;
      w_loads++;
      if (par_char[6:0] == 7'b1111100) begin
        w_commas++;
        if (char_clkn !== 1'b1) w_wrong++;
      end
      since = 0;
      prev_clkn = char_clkn;
    end
  endtask

  task automatic send_char(input logic [9:0] c);
    for (int i = 0; i < 10; i++) send_bit(c[i]);
  endtask

  task automatic send_pairs(input int n);
    for (int i = 0; i < n; i++) begin
      send_char(K_CHAR);
      send_char(D_CHAR);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(par_char === 10'd0, "R2", "reset par_char", par_char, 0);
    check(char_clkn === 1'b0, "R2", "reset char_clkn", char_clkn, 0);
    check(char_clk === 1'b1, "R2", "reset char_clk", char_clk, 1);
    check(comma_hit === 1'b0, "R9", "reset comma_hit", comma_hit, 0);
    rst_n = 1'b1;
    since = 0;
    prev_clkn = 1'b0;
  endtask

  // R3 R4: search off, commas three bits off the grid
  task automatic t_hold_disabled();
    align_en = 1'b0;
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    send_pairs(2);
    window_start();
    send_pairs(10);
    check(w_min == 10 && w_max == 10, "R3", "nominal period min", w_min, 10);
    check(w_max == 10, "R4", "disabled period max", w_max, 10);
    check(w_commas == 0, "R4", "no realignment while disabled", w_commas, 0);
  endtask

  // R5 R7: search on, grid moves once then stays
  task automatic t_realign();
    align_en = 1'b1;
    send_pairs(3);
    window_start();
    send_pairs(12);
    check(w_commas == 12, "R5", "commas framed", w_commas, 12);
    check(w_wrong == 0, "R5", "commas on complement edge", w_wrong, 0);
    check(w_min == 10 && w_max == 10, "R7", "aligned commas keep period", w_max, 10);
    check(w_loads == 24, "R7", "loads in window", w_loads, 24);
  endtask

  // R8: one extra character puts commas on the true edge
  task automatic t_phase_slip();
    send_char(D_CHAR);
    window_start();
    send_pairs(8);
    check(w_max == 20, "R8", "single-character stretch", w_max, 20);
    check(w_min == 10, "R8", "period otherwise nominal", w_min, 10);
    check(w_commas == 7, "R8", "first comma dropped", w_commas, 7);
    check(w_wrong == 0, "R8", "commas back on complement edge", w_wrong, 0);
  endtask

  // R4: disabled again, offset stream keeps old grid
  task automatic t_disable_shift();
    align_en = 1'b0;
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    window_start();
    send_pairs(10);
    check(w_min == 10 && w_max == 10, "R4", "grid held after offset", w_max, 10);
    check(w_commas == 0, "R4", "offset commas not framed", w_commas, 0);
  endtask

  // R5 R6: re-enable and reacquire from an offset grid
  task automatic t_reacquire();
    align_en = 1'b1;
    window_start();
    send_pairs(14);
    check(w_min >= 10, "R6", "no short period on reacquire", w_min, 10);
    check(w_wrong == 0, "R5", "reacquired commas on complement edge", w_wrong, 0);
    check(w_commas >= 12, "R5", "commas after reacquire", w_commas, 12);
    window_start();
    send_pairs(6);
    check(w_commas == 6 && w_wrong == 0, "R5", "steady framing", w_commas, 6);
    check(w_min == 10 && w_max == 10, "R7", "steady period", w_max, 10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "ALL", "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_hold_disabled();
    t_realign();
    t_phase_slip();
    t_disable_shift();
    t_reacquire();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule